// File: doc/BRIEF.md
# Serial GPIO Pin Interrupt Detector

This block sits behind a serial GPIO bitstream engine and watches the input samples it delivers. The pins are arranged as a grid of ports by bit indices (32 by 4 by default). Once per frame the engine presents a complete snapshot and pulses a strobe. The block compares each pin's new sample with the one from the previous frame, or with a programmed level. It records a pending event per pin and drives one combined interrupt line.

Each pin has a two-bit trigger type, a level polarity, an enable and a write-one acknowledge, and it exposes a readable identity flag. Software reaches these through a register-select, index and data write port and a combinational read port. Every register holds one word per bit index, and the port number picks the bit inside the word. The two bits of the trigger type sit in two separate banks of words. A single master enable gates the combined output.

Top module: `sgpio_irq_detect`

## Requirements
- R1: After reset, trigger types, polarities, enables, pending events, previous samples and the master enable are all 0, and `irq` is 0.
- R2: Register select codes are 0 trigger, 1 polarity, 2 enable, 3 acknowledge, 4 identity and 5 master configuration (bit 0). For every register the port number is the bit position. For trigger, index b holds type bit 0 and index NBIT+b holds type bit 1 of bit index b. For polarity, enable, acknowledge and identity, the index is the bit index. Reads return what was written. An unused index or an acknowledge read returns 0.
- R3: When `frame_valid` is high, the snapshot `frame_data[b*NPORT+p]` for port p and bit index b is evaluated and becomes the new previous sample. Input changes without `frame_valid` have no effect.
- R4: Trigger type 0 is level detection. With polarity 0 a frame sample of 1 sets the pending event, and with polarity 1 a sample of 0 sets it. The event is set again on every frame while the level stays active, including after an acknowledge.
- R5: Trigger type 1 sets the pending event on a frame whose sample differs from the previous one.
- R6: Trigger type 2 sets the pending event on a frame whose sample goes from 1 to 0.
- R7: Trigger type 3 sets the pending event on a frame whose sample goes from 0 to 1. A steady 1 or a falling sample does not set it.
- R8: Writing 1 to an acknowledge bit clears that pin's pending event, and 0 bits leave events alone. When a frame sets the event in the same cycle, the new event wins.
- R9: An identity bit reads as pending AND enable. An event is recorded while its pin is disabled and shows once the pin is enabled.
- R10: `irq` is high exactly when the master enable is 1 and at least one identity bit is 1.
- R11: Writes to the identity register, and writes to polarity, enable or acknowledge with an index of NBIT or more, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_valid | input | 1 | Snapshot strobe, one cycle per frame |
| frame_data | input | NBIT*NPORT | Sampled pins, bit b*NPORT+p for port p, bit index b |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_idx | input | $clog2(2*NBIT) | Word index for the write |
| wr_data | input | NPORT | Write data, one bit per port |
| rd_sel | input | 3 | Register select for the read |
| rd_idx | input | $clog2(2*NBIT) | Word index for the read |
| rd_data | output | NPORT | Combinational read data |
| irq | output | 1 | Combined interrupt |

## Verification
Each trigger type is driven on its own pin with rising, steady-high, falling and steady-low frame sequences. The pattern shows which sample pairs set an event: a rising detector must ignore a held 1 and a falling step, and an either-edge detector must fire on both. Level pins are held active across acknowledges under both polarities, which separates level re-arming from a one-shot edge. Input changes without a frame strobe, an acknowledge in the same cycle as a frame, enabling a pin after its event, and master gating each separate a timing or ordering mistake from correct behaviour.

// File: rtl/sgpio_irq_detect.sv
module sgpio_irq_detect #(
  parameter int NPORT = 32,
  parameter int NBIT  = 4,
  localparam int IW   = $clog2(2 * NBIT)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_valid,
  input  logic [NBIT*NPORT-1:0] frame_data,
  input  logic                  wr_en,
  input  logic [2:0]            wr_sel,
  input  logic [IW-1:0]         wr_idx,
  input  logic [NPORT-1:0]      wr_data,
  input  logic [2:0]            rd_sel,
  input  logic [IW-1:0]         rd_idx,
  output logic [NPORT-1:0]      rd_data,
  output logic                  irq
);

  localparam logic [2:0] SEL_TRIG  = 3'd0;
  localparam logic [2:0] SEL_POL   = 3'd1;
  localparam logic [2:0] SEL_ENA   = 3'd2;
  localparam logic [2:0] SEL_ACK   = 3'd3;
  localparam logic [2:0] SEL_IDENT = 3'd4;
  localparam logic [2:0] SEL_MCFG  = 3'd5;

  logic [NPORT-1:0] trg_lo [NBIT];
  logic [NPORT-1:0] trg_hi [NBIT];
  logic [NPORT-1:0] pol    [NBIT];
  logic [NPORT-1:0] ena    [NBIT];
  logic [NPORT-1:0] pend   [NBIT];
  logic [NPORT-1:0] prev   [NBIT];
  logic [NPORT-1:0] ident  [NBIT];
  logic [NBIT-1:0]  any_id;
  logic [NBIT*NPORT-1:0] pend_flat, prev_flat;
  logic master;

  for (genvar b = 0; b < NBIT; b++) begin : g_bit
    logic [NPORT-1:0] cur, hit, ackm;
    logic sel_b;

    assign cur   = frame_data[b*NPORT +: NPORT];
    assign sel_b = wr_en && (wr_idx == IW'(b));
    assign ackm  = (sel_b && wr_sel == SEL_ACK) ? wr_data : '0;
    assign hit   = (~trg_hi[b] & ~trg_lo[b] & (cur ^ pol[b]))
                 | (~trg_hi[b] &  trg_lo[b] & (cur ^ prev[b]))
                 | ( trg_hi[b] & ~trg_lo[b] & (prev[b] & ~cur))
                 | ( trg_hi[b] &  trg_lo[b] & (~prev[b] & cur));
    assign ident[b]  = pend[b] & ena[b];
    assign any_id[b] = |ident[b];
    assign pend_flat[b*NPORT +: NPORT] = pend[b];
    assign prev_flat[b*NPORT +: NPORT] = prev[b];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        trg_lo[b] <= '0;
        trg_hi[b] <= '0;
        pol[b]    <= '0;
        ena[b]    <= '0;
        pend[b]   <= '0;
        prev[b]   <= '0;
      end else begin
        if (frame_valid) prev[b] <= cur;
        if (sel_b && wr_sel == SEL_TRIG) trg_lo[b] <= wr_data;
        if (wr_en && wr_sel == SEL_TRIG && wr_idx == IW'(NBIT + b)) trg_hi[b] <= wr_data;
        if (sel_b && wr_sel == SEL_POL) pol[b] <= wr_data;
        if (sel_b && wr_sel == SEL_ENA) ena[b] <= wr_data;
        pend[b] <= (pend[b] & ~ackm) | (frame_valid ? hit : '0);
      end
    end

    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_b && wr_sel == SEL_ACK && !frame_valid) |=> ((pend[b] & $past(wr_data)) == '0));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) master <= 1'b0;
    else if (wr_en && wr_sel == SEL_MCFG) master <= wr_data[0];
  end

  assign irq = master & (|any_id);

  always_comb begin
    rd_data = '0;
    for (int b = 0; b < NBIT; b++) begin
      if (rd_idx == IW'(b)) begin
        case (rd_sel)
          SEL_TRIG:  rd_data = trg_lo[b];
          SEL_POL:   rd_data = pol[b];
          SEL_ENA:   rd_data = ena[b];
          SEL_IDENT: rd_data = ident[b];
          default:   ;
        endcase
      end
      if (rd_sel == SEL_TRIG && rd_idx == IW'(NBIT + b)) rd_data = trg_hi[b];
    end
    if (rd_sel == SEL_MCFG) rd_data = NPORT'(master);
  end

  a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> (prev_flat == $past(frame_data)));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |=> $stable(prev_flat));

  a_r4_set_only_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |=> ((pend_flat & ~$past(pend_flat)) == '0));

  a_r10_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend_flat != '0));

endmodule

// File: tb/sgpio_irq_detect_bench.sv
module sgpio_irq_detect_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 32;
  localparam int NB = 4;
  localparam int IW = $clog2(2 * NB);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_valid = 1'b0;
  logic [NB*NP-1:0] frame_data = '0;
  logic wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [IW-1:0] wr_idx = '0;
  logic [NP-1:0] wr_data = '0;
  logic [2:0] rd_sel = '0;
  logic [IW-1:0] rd_idx = '0;
  logic [NP-1:0] rd_data;
  logic irq;

  logic [NB*NP-1:0] fv = '0;
  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];
  event ev_chk;

  sgpio_irq_detect #(.NPORT(NP), .NBIT(NB)) u_sgpio_irq_detect (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_data(frame_data),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_idx(rd_idx), .rd_data(rd_data), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(ev_chk) begin
    item_t it;
    logic [31:0] act;
    it = q.pop_front();
    act = it.is_irq ? {31'b0, irq} : rd_data;
    compared++;
    if (act !== it.exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] s, input int i, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_idx = IW'(i); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic frm();
    @(negedge clk);
    frame_valid = 1'b1; frame_data = fv;
    @(negedge clk);
    frame_valid = 1'b0;
  endtask

  task automatic wr_frm(input logic [2:0] s, input int i, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_idx = IW'(i); wr_data = d;
    frame_valid = 1'b1; frame_data = fv;
    @(negedge clk);
    wr_en = 1'b0; frame_valid = 1'b0;
  endtask

  task automatic pin(input int p, input int b, input bit v);
    fv[b*NP + p] = v;
  endtask

  task automatic exp_reg(input logic [2:0] s, input int i, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    rd_sel = s; rd_idx = IW'(i);
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    q.push_back(it);
    #1 ->ev_chk;
  endtask

  task automatic exp_irq(input bit e, input string tag);
    item_t it;
    @(negedge clk);
    it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
    q.push_back(it);
    #1 ->ev_chk;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    exp_irq(0, "R1 irq after reset");
    exp_reg(2, 0, 0, "R1 enable after reset");
    exp_reg(4, 3, 0, "R1 identity after reset");
    exp_reg(0, 0, 0, "R1 trigger after reset");
    exp_reg(5, 0, 0, "R1 master after reset");

    wr(0, 5, 32'hA5A50001);
    exp_reg(0, 5, 32'hA5A50001, "R2 trigger high bank readback");
    exp_reg(0, 1, 0, "R2 trigger low bank separate");
    wr(1, 2, 32'h00001234);
    exp_reg(1, 2, 32'h00001234, "R2 polarity readback");
    exp_reg(3, 0, 0, "R2 acknowledge reads 0");
    wr(0, 5, 0);
    wr(1, 2, 0);
    wr(5, 0, 1);
    exp_reg(5, 0, 1, "R2 master readback");

    // rising pin: port 3, bit index 0
    wr(0, 0, 32'h8); wr(0, 4, 32'h8); wr(2, 0, 32'h8);
    frm();
    exp_reg(4, 0, 0, "R7 idle frame");
    pin(3, 0, 1);
    @(negedge clk); frame_data = fv;
    repeat (2) @(negedge clk);
    exp_reg(4, 0, 0, "R3 no strobe no effect");
    frm();
    exp_reg(4, 0, 32'h8, "R7 rising sets");
    exp_irq(1, "R10 irq with identity");
    wr(3, 0, 32'h8);
    exp_reg(4, 0, 0, "R8 acknowledge clears");
    exp_irq(0, "R10 irq after ack");
    frm();
    exp_reg(4, 0, 0, "R7 steady high ignored");
    pin(3, 0, 0); frm();
    exp_reg(4, 0, 0, "R7 falling ignored");

    // falling pin: port 7, bit index 1
    wr(0, 5, 32'h80); wr(2, 1, 32'h80);
    pin(7, 1, 1); frm();
    exp_reg(4, 1, 0, "R6 rising ignored");
    pin(7, 1, 0); frm();
    exp_reg(4, 1, 32'h80, "R6 falling sets");
    exp_irq(1, "R10 irq on falling");
    wr(3, 1, 32'h80);

    // either edge: port 10, bit index 2
    wr(0, 2, 32'h400); wr(2, 2, 32'h400);
    pin(10, 2, 1); frm();
    exp_reg(4, 2, 32'h400, "R5 rise sets");
    wr(3, 2, 32'h400);
    frm();
    exp_reg(4, 2, 0, "R5 steady ignored");
    pin(10, 2, 0); frm();
    exp_reg(4, 2, 32'h400, "R5 fall sets");
    wr(3, 2, 32'h400);
    exp_reg(4, 2, 0, "R8 ack either edge");

    // level pin: port 20, bit index 3
    wr(2, 3, 32'h100000);
    pin(20, 3, 1); frm();
    exp_reg(4, 3, 32'h100000, "R4 level high sets");
    wr(3, 3, 32'h100000);
    exp_reg(4, 3, 0, "R8 level ack");
    frm();
    exp_reg(4, 3, 32'h100000, "R4 level re-sets");
    wr_frm(3, 3, 32'h100000);
    exp_reg(4, 3, 32'h100000, "R8 same-cycle event wins");
    wr(1, 3, 32'h100000);
    wr(3, 3, 32'h100000);
    frm();
    exp_reg(4, 3, 0, "R4 active-low ignores high");
    pin(20, 3, 0); frm();
    exp_reg(4, 3, 32'h100000, "R4 active-low sets on low");

    // disabled pin: port 25, bit index 3
    wr(2, 3, 0);
    pin(25, 3, 1); frm();
    exp_reg(4, 3, 0, "R9 disabled pin hidden");
    wr(2, 3, 32'h02000000);
    exp_reg(4, 3, 32'h02000000, "R9 pending shows after enable");
    exp_irq(1, "R10 irq from late enable");
    wr(5, 0, 0);
    exp_irq(0, "R10 master off");
    exp_reg(4, 3, 32'h02000000, "R10 identity kept with master off");
    wr(5, 0, 1);
    exp_irq(1, "R10 master on");

    wr(4, 3, 0);
    exp_reg(4, 3, 32'h02000000, "R11 identity write ignored");
    wr(2, 5, 32'hFFFFFFFF);
    exp_reg(2, 1, 32'h80, "R11 out-of-range enable ignored");
    exp_reg(2, 5, 0, "R2 unused index reads 0");
    wr(3, 3, ~32'h02000000);
    exp_reg(4, 3, 32'h02000000, "R8 zero bits leave event");
    wr(3, 3, 32'h02000000);
    exp_reg(4, 3, 0, "R8 final ack");
    exp_irq(0, "R10 irq clear at end");

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule